// File: doc/BRIEF.md
# Gradient Motion Moment Accumulator

This block takes two 8-bit image streams that arrive pixel by pixel in raster order. From the first image it forms a 3x3 neighbourhood and computes a horizontal and a vertical gradient with programmable kernels. It also forms a temporal term from the centre pixels of both images, either as their sum or as their difference. The two spatial gradients are sent back out as a stream, one result for each input pixel.

Six multiply-accumulate units each multiply two chosen terms and one position weight taken from the window-centre coordinates. Each unit adds its product into a signed 48-bit running total that covers the whole frame. The totals are the moments of an affine image-registration system. That system has 24 distinct moments, so a host gathers them in four frame passes and reprograms the unit selections between passes. After the frame-complete pulse the host reads the totals through a small select-and-read port.

Pixels are left out of the totals in two cases. The first is a window centre that lacks a full 3x3 neighbourhood. The second, when masking is enabled, is a centre whose pixel in either image equals the mask code.

Top module: `motion_moment_acc`

## Requirements
- R1: Gradients use a difference kernel d (three signed 4-bit taps in `k_diff`, tap i at bits [4i+3:4i]) and a smoothing kernel s (same packing in `k_smooth`). Tap index 0 applies to the left column or the top row. Over the window whose centre is (x-1, y-1) for an input pixel at (x, y), `gx_out` = Σrow s[row]·Σcol d[col]·A and `gy_out` = Σcol s[col]·Σrow d[row]·A. `grad_valid` is high exactly in the cycle after each cycle with `in_valid` high, and carries that pixel's result.
- R2: The temporal term is A−B at the window centre when `it_sub`=1 and A+B when `it_sub`=0.
- R3: The column counter is 0 on a pixel with `in_sol` and advances by one per valid pixel. The row counter is 0 on a pixel with `in_sof` and advances by one on each later `in_sol`. Idle cycles change neither counter. Weights use the centre coordinates (x-1, y-1).
- R4: `acc_cfg` holds one 7-bit field per unit; unit i is at bits [7i+6:7i]. In each field, bits [1:0] are factor A, bits [3:2] are factor B and bits [6:4] are the weight. Factor codes are 0=horizontal gradient, 1=vertical gradient, 2=temporal term and 3=zero. Weight codes are 0=1, 1=x, 2=y, 3=x², 4=x·y and 5=y²; codes 6 and 7 give 0. Each unit sums A·B·weight over the contributing pixels of the frame.
- R5: A centre contributes only if the input pixel has column ≥ 2 and row ≥ 2, so one-pixel borders are excluded.
- R6: With `mask_en`=1, a centre whose A or B pixel equals `mask_code` does not contribute. With `mask_en`=0, mask-valued pixels are accumulated normally.
- R7: All totals read 0 after reset. A pixel with `in_sof` clears every total, so each frame starts from zero.
- R8: `frame_done` is high for one cycle, three cycles after the cycle in which the pixel with `in_eof` is presented. `rd_data` then shows the signed total of unit `rd_sel`, and reads 0 for `rd_sel` ≥ 6.
- R9: `gx_out` and `gy_out` hold their values through cycles without a valid pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_sol | input | 1 | Pixel is first of its line |
| in_sof | input | 1 | Pixel is first of the frame |
| in_eof | input | 1 | Pixel is last of the frame |
| in_a | input | 8 | Pixel of first image |
| in_b | input | 8 | Pixel of second image |
| it_sub | input | 1 | 1: temporal term A−B, 0: A+B |
| mask_en | input | 1 | Enable mask exclusion |
| mask_code | input | 8 | Pixel value that marks a masked pixel |
| k_diff | input | 12 | Difference kernel taps |
| k_smooth | input | 12 | Smoothing kernel taps |
| acc_cfg | input | 42 | Factor and weight selection for six units |
| rd_sel | input | 3 | Total to read |
| grad_valid | output | 1 | Gradient outputs carry a new result |
| gx_out | output | 18 | Horizontal gradient, signed |
| gy_out | output | 18 | Vertical gradient, signed |
| frame_done | output | 1 | Frame totals complete |
| rd_data | output | 48 | Selected total, signed |

## Verification
Each gradient pair is due one cycle after its pixel is presented. The driver queues the expected pair as it drives the pixel, and the monitor pops the queue each time `grad_valid` is high, so the comparison tracks arrival order rather than counting cycles. Frame totals are due three cycles after the final pixel. The bench confirms `frame_done` is low two cycles after that pixel's presentation cycle, high one cycle later and low again after that. It reads the totals only after this pulse, including on a frame driven with idle gaps between pixels.

// File: rtl/mma_pkg.sv
package mma_pkg;

    localparam int PIX_W = 8;

    typedef logic [PIX_W-1:0] pix_t;

    // one column of the 3x3 window, oldest row on top
    typedef struct packed {
        pix_t top;
        pix_t mid;
        pix_t bot;
    } col_t;

    // line memory word: A two rows up, A one row up, B one row up
    typedef struct packed {
        pix_t a_up;
        pix_t a;
        pix_t b;
    } line_word_t;

    typedef enum logic [1:0] {
        FAC_GX   = 2'd0,
        FAC_GY   = 2'd1,
        FAC_GT   = 2'd2,
        FAC_ZERO = 2'd3
    } factor_e;

    typedef enum logic [2:0] {
        WT_ONE  = 3'd0,
        WT_X    = 3'd1,
        WT_Y    = 3'd2,
        WT_XX   = 3'd3,
        WT_XY   = 3'd4,
        WT_YY   = 3'd5,
        WT_NIL6 = 3'd6,
        WT_NIL7 = 3'd7
    } weight_e;

    typedef struct packed {
        weight_e wt;
        factor_e fb;
        factor_e fa;
    } mac_cfg_t;

    localparam int CFG_W = $bits(mac_cfg_t);

    function automatic int larger(input int p, input int q);
        return (p > q) ? p : q;
    endfunction

endpackage

// File: rtl/mma_window.sv
module mma_window
    import mma_pkg::*;
#(
    parameter int LINE_MAX = 64,
    parameter int ROW_MAX  = 64,
    parameter int XW       = $clog2(LINE_MAX),
    parameter int YW       = $clog2(ROW_MAX)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_sol,
    input  logic                in_sof,
    input  pix_t                a_in,
    input  pix_t                b_in,
    output pix_t [2:0][2:0]     win,
    output pix_t                ctr_b,
    output logic [XW-1:0]       ctr_x,
    output logic [YW-1:0]       ctr_y,
    output logic                inner
);

    logic [XW-1:0] x_q, x_now;
    logic [YW-1:0] y_q, y_now;
    line_word_t    lmem [LINE_MAX];
    line_word_t    rd;
    col_t          col_now, col_d1, col_d2;
    pix_t          b_d1;

    always_comb begin
        x_now = in_sol ? '0 : x_q;
        if (in_sof)
            y_now = '0;
        else if (in_sol)
            y_now = y_q + YW'(1);
        else
            y_now = y_q;
    end

    assign rd = lmem[x_now];

    always_comb begin
        col_now.top = rd.a_up;
        col_now.mid = rd.a;
        col_now.bot = a_in;
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            lmem[x_now] <= '{a_up: rd.a, a: a_in, b: b_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            col_d1 <= '0;
            col_d2 <= '0;
            b_d1   <= '0;
        end else if (in_valid) begin
            x_q    <= x_now + XW'(1);
            y_q    <= y_now;
            col_d2 <= col_d1;
            col_d1 <= col_now;
            b_d1   <= rd.b;
        end
    end

    always_comb begin
        win[0][0] = col_d2.top;
        win[0][1] = col_d1.top;
        win[0][2] = col_now.top;
        win[1][0] = col_d2.mid;
        win[1][1] = col_d1.mid;
        win[1][2] = col_now.mid;
        win[2][0] = col_d2.bot;
        win[2][1] = col_d1.bot;
        win[2][2] = col_now.bot;
    end

    assign ctr_b = b_d1;
    assign ctr_x = x_now - XW'(1);
    assign ctr_y = y_now - YW'(1);
    assign inner = (x_now >= XW'(2)) && (y_now >= YW'(2));

endmodule

// File: rtl/mma_gradient.sv
module mma_gradient
    import mma_pkg::*;
#(
    parameter int GRAD_W = 18,
    parameter int TAP_W  = 4,
    localparam int KW    = 3 * TAP_W
) (
    input  pix_t [2:0][2:0]           win,
    input  pix_t                      ctr_b,
    input  logic [KW-1:0]             k_diff,
    input  logic [KW-1:0]             k_smooth,
    input  logic                      it_sub,
    output logic signed [GRAD_W-1:0]  gx,
    output logic signed [GRAD_W-1:0]  gy,
    output logic signed [GRAD_W-1:0]  gt
);

    function automatic logic signed [GRAD_W-1:0] px(input pix_t p);
        return $signed({{(GRAD_W-PIX_W){1'b0}}, p});
    endfunction

    function automatic logic signed [GRAD_W-1:0] tap(input logic [KW-1:0] k, input int i);
        logic [TAP_W-1:0] t;
        t = k[i*TAP_W +: TAP_W];
        return $signed({{(GRAD_W-TAP_W){t[TAP_W-1]}}, t});
    endfunction

    logic signed [GRAD_W-1:0] hsum [3];
    logic signed [GRAD_W-1:0] vsum [3];

    always_comb begin
        for (int r = 0; r < 3; r++) begin
            hsum[r] = '0;
            vsum[r] = '0;
            for (int c = 0; c < 3; c++) begin
                hsum[r] = hsum[r] + tap(k_diff, c) * px(win[r][c]);
                vsum[r] = vsum[r] + tap(k_diff, c) * px(win[c][r]);
            end
        end
        gx = '0;
        gy = '0;
        for (int r = 0; r < 3; r++) begin
            gx = gx + tap(k_smooth, r) * hsum[r];
            gy = gy + tap(k_smooth, r) * vsum[r];
        end
        gt = it_sub ? (px(win[1][1]) - px(ctr_b)) : (px(win[1][1]) + px(ctr_b));
    end

endmodule

// File: rtl/mma_mac_unit.sv
module mma_mac_unit
    import mma_pkg::*;
#(
    parameter int GRAD_W = 18,
    parameter int CW     = 6,
    parameter int ACC_W  = 48,
    localparam int WW    = 2 * CW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  mac_cfg_t                 cfg,
    input  logic                     take,
    input  logic signed [GRAD_W-1:0] gx,
    input  logic signed [GRAD_W-1:0] gy,
    input  logic signed [GRAD_W-1:0] gt,
    input  logic [CW-1:0]            pos_x,
    input  logic [CW-1:0]            pos_y,
    input  logic                     add_en,
    input  logic                     add_use,
    input  logic                     add_clear,
    output logic [ACC_W-1:0]         acc
);

    function automatic logic signed [ACC_W-1:0] widen(input logic signed [GRAD_W-1:0] v);
        return $signed({{(ACC_W-GRAD_W){v[GRAD_W-1]}}, v});
    endfunction

    function automatic logic signed [ACC_W-1:0] pick(input factor_e f,
                                                     input logic signed [GRAD_W-1:0] h,
                                                     input logic signed [GRAD_W-1:0] v,
                                                     input logic signed [GRAD_W-1:0] t);
        case (f)
            FAC_GX:  return widen(h);
            FAC_GY:  return widen(v);
            FAC_GT:  return widen(t);
            default: return '0;
        endcase
    endfunction

    logic [WW-1:0]            xw, yw, wt_val;
    logic signed [ACC_W-1:0]  fa_v, fb_v, wt_s, prod_next, prod_q;

    always_comb begin
        xw = WW'(pos_x);
        yw = WW'(pos_y);
        case (cfg.wt)
            WT_ONE:  wt_val = WW'(1);
            WT_X:    wt_val = xw;
            WT_Y:    wt_val = yw;
            WT_XX:   wt_val = xw * xw;
            WT_XY:   wt_val = xw * yw;
            WT_YY:   wt_val = yw * yw;
            default: wt_val = '0;
        endcase
        fa_v      = pick(cfg.fa, gx, gy, gt);
        fb_v      = pick(cfg.fb, gx, gy, gt);
        wt_s      = $signed({{(ACC_W-WW){1'b0}}, wt_val});
        prod_next = fa_v * fb_v * wt_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            acc    <= '0;
        end else begin
            if (take)
                prod_q <= prod_next;
            if (add_en)
                acc <= (add_clear ? '0 : acc) + (add_use ? prod_q : '0);
        end
    end

endmodule

// File: rtl/motion_moment_acc.sv
module motion_moment_acc
    import mma_pkg::*;
#(
    parameter int LINE_MAX = 64,
    parameter int ROW_MAX  = 64,
    parameter int GRAD_W   = 18,
    parameter int TAP_W    = 4,
    parameter int ACC_W    = 48,
    parameter int N_ACC    = 6,
    localparam int SEL_W   = $clog2(N_ACC + 1),
    localparam int KW      = 3 * TAP_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic                      in_sol,
    input  logic                      in_sof,
    input  logic                      in_eof,
    input  logic [PIX_W-1:0]          in_a,
    input  logic [PIX_W-1:0]          in_b,
    input  logic                      it_sub,
    input  logic                      mask_en,
    input  logic [PIX_W-1:0]          mask_code,
    input  logic [KW-1:0]             k_diff,
    input  logic [KW-1:0]             k_smooth,
    input  logic [N_ACC*CFG_W-1:0]    acc_cfg,
    input  logic [SEL_W-1:0]          rd_sel,
    output logic                      grad_valid,
    output logic signed [GRAD_W-1:0]  gx_out,
    output logic signed [GRAD_W-1:0]  gy_out,
    output logic                      frame_done,
    output logic [ACC_W-1:0]          rd_data
);

    localparam int XW = $clog2(LINE_MAX);
    localparam int YW = $clog2(ROW_MAX);
    localparam int CW = larger(XW, YW);

    pix_t [2:0][2:0]          win;
    pix_t                     ctr_b;
    logic [XW-1:0]            ctr_x;
    logic [YW-1:0]            ctr_y;
    logic                     inner;
    logic                     masked;
    logic signed [GRAD_W-1:0] gx_c, gy_c, gt_c;

    mma_window #(
        .LINE_MAX (LINE_MAX),
        .ROW_MAX  (ROW_MAX),
        .XW       (XW),
        .YW       (YW)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .in_sof   (in_sof),
        .a_in     (in_a),
        .b_in     (in_b),
        .win      (win),
        .ctr_b    (ctr_b),
        .ctr_x    (ctr_x),
        .ctr_y    (ctr_y),
        .inner    (inner)
    );

    mma_gradient #(
        .GRAD_W   (GRAD_W),
        .TAP_W    (TAP_W)
    ) u_gradient (
        .win      (win),
        .ctr_b    (ctr_b),
        .k_diff   (k_diff),
        .k_smooth (k_smooth),
        .it_sub   (it_sub),
        .gx       (gx_c),
        .gy       (gy_c),
        .gt       (gt_c)
    );

    assign masked = mask_en && ((win[1][1] == mask_code) || (ctr_b == mask_code));

    // stage 1: gradients, centre position and contribution flag
    logic                     s1_valid, s1_use, s1_sof, s1_eof;
    logic signed [GRAD_W-1:0] s1_gx, s1_gy, s1_gt;
    logic [CW-1:0]            s1_x, s1_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_use   <= 1'b0;
            s1_sof   <= 1'b0;
            s1_eof   <= 1'b0;
            s1_gx    <= '0;
            s1_gy    <= '0;
            s1_gt    <= '0;
            s1_x     <= '0;
            s1_y     <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_use <= inner && !masked;
                s1_sof <= in_sof;
                s1_eof <= in_eof;
                s1_gx  <= gx_c;
                s1_gy  <= gy_c;
                s1_gt  <= gt_c;
                s1_x   <= CW'(ctr_x);
                s1_y   <= CW'(ctr_y);
            end
        end
    end

    // stage 2: control that travels alongside the registered products
    logic s2_valid, s2_use, s2_sof, s2_eof;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid   <= 1'b0;
            s2_use     <= 1'b0;
            s2_sof     <= 1'b0;
            s2_eof     <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            s2_valid   <= s1_valid;
            s2_use     <= s1_use;
            s2_sof     <= s1_sof;
            s2_eof     <= s1_eof;
            frame_done <= s2_valid && s2_eof;
        end
    end

    logic [N_ACC-1:0][ACC_W-1:0] acc_all;

    for (genvar g = 0; g < N_ACC; g++) begin : g_mac
        mma_mac_unit #(
            .GRAD_W    (GRAD_W),
            .CW        (CW),
            .ACC_W     (ACC_W)
        ) u_mac (
            .clk       (clk),
            .rst       (rst),
            .cfg       (mac_cfg_t'(acc_cfg[g*CFG_W +: CFG_W])),
            .take      (s1_valid),
            .gx        (s1_gx),
            .gy        (s1_gy),
            .gt        (s1_gt),
            .pos_x     (s1_x),
            .pos_y     (s1_y),
            .add_en    (s2_valid),
            .add_use   (s2_use),
            .add_clear (s2_sof),
            .acc       (acc_all[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_ACC; i++) begin
            if (int'(rd_sel) == i)
                rd_data = acc_all[i];
        end
    end

    assign grad_valid = s1_valid;
    assign gx_out     = s1_gx;
    assign gy_out     = s1_gy;

endmodule

// File: rtl/mma_checker.sv
module mma_checker #(
    parameter int GRAD_W = 18,
    parameter int ACC_W  = 48,
    parameter int SEL_W  = 3,
    parameter int N_ACC  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_sof,
    input logic              in_eof,
    input logic              grad_valid,
    input logic [GRAD_W-1:0] gx_out,
    input logic [GRAD_W-1:0] gy_out,
    input logic              frame_done,
    input logic [SEL_W-1:0]  rd_sel,
    input logic [ACC_W-1:0]  rd_data
);

    AST_PIXEL_GIVES_GRAD: assert property (@(posedge clk) disable iff (rst) in_valid |=> grad_valid) else $error("gradient missing after pixel"); // R1

    AST_GRAD_NEEDS_PIXEL: assert property (@(posedge clk) disable iff (rst) grad_valid |-> $past(in_valid)) else $error("gradient without pixel"); // R1

    AST_GRAD_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(gx_out) && $stable(gy_out))) else $error("gradient moved while idle"); // R9

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst) $past(in_valid && in_eof, 3) |-> frame_done) else $error("frame_done late"); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) frame_done |=> !frame_done) else $error("frame_done too long"); // R8

    AST_CLEARED_AT_START: assert property (@(posedge clk) disable iff (rst) $past(in_valid && in_sof, 3) |-> (rd_data == '0)) else $error("totals not cleared"); // R7

    AST_READ_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst) (int'(rd_sel) >= N_ACC) |-> (rd_data == '0)) else $error("unused select not zero"); // R8

endmodule

bind motion_moment_acc mma_checker #(
    .GRAD_W (GRAD_W),
    .ACC_W  (ACC_W),
    .SEL_W  (SEL_W),
    .N_ACC  (N_ACC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .grad_valid (grad_valid),
    .gx_out     (gx_out),
    .gy_out     (gy_out),
    .frame_done (frame_done),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data)
);

// File: tb/motion_moment_acc_test.sv
`timescale 1ns/1ps
module motion_moment_acc_test;

    localparam int GW = 18;
    localparam int AW = 48;
    localparam int NA = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]    in_a = '0, in_b = '0;
    logic          it_sub = 1'b0, mask_en = 1'b0;
    logic [7:0]    mask_code = '0;
    logic [11:0]   k_diff = '0, k_smooth = '0;
    logic [41:0]   acc_cfg = '0;
    logic [2:0]    rd_sel = '0;
    logic          grad_valid, frame_done;
    logic signed [GW-1:0] gx_out, gy_out;
    logic [AW-1:0] rd_data;

    motion_moment_acc uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
        .in_eof(in_eof), .in_a(in_a), .in_b(in_b), .it_sub(it_sub), .mask_en(mask_en),
        .mask_code(mask_code), .k_diff(k_diff), .k_smooth(k_smooth), .acc_cfg(acc_cfg),
        .rd_sel(rd_sel), .grad_valid(grad_valid), .gx_out(gx_out), .gy_out(gy_out),
        .frame_done(frame_done), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        bit chk;
        int gx;
        int gy;
    } gexp_t;
    gexp_t gq[$];

    int img_a [0:15][0:15];
    int img_b [0:15][0:15];
    int kd[3];
    int ks[3];
    int cf_a[NA];
    int cf_b[NA];
    int cf_w[NA];
    int unsigned seed = 32'h1234_5678;

    task automatic check(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    function automatic int rnd8();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'hFF);
    endfunction

    function automatic int grad_model(input bit vert, input int xc, input int yc);
        int s = 0;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++)
                if (!vert) s += ks[r] * kd[c] * img_a[yc-1+r][xc-1+c];
                else       s += ks[c] * kd[r] * img_a[yc-1+r][xc-1+c];
        return s;
    endfunction

    function automatic longint fac(input int sel, input int ix, input int iy, input int it);
        case (sel)
            0: return longint'(ix);
            1: return longint'(iy);
            2: return longint'(it);
            default: return 0;
        endcase
    endfunction

    function automatic longint wt(input int sel, input int x, input int y);
        case (sel)
            0: return 1;
            1: return x;
            2: return y;
            3: return x * x;
            4: return x * y;
            5: return y * y;
            default: return 0;
        endcase
    endfunction

    task automatic apply_cfg();
        for (int i = 0; i < NA; i++)
            acc_cfg[i*7 +: 7] = 7'((cf_w[i] << 4) | (cf_b[i] << 2) | cf_a[i]);
        for (int c = 0; c < 3; c++) begin
            k_diff[c*4 +: 4]   = 4'(kd[c]);
            k_smooth[c*4 +: 4] = 4'(ks[c]);
        end
    endtask

    // driver: presents pixels and queues the expected gradient for each
    task automatic drive_frame(input int w, input int h, input int gap);
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                gexp_t e;
                @(negedge clk);
                in_valid = 1'b1;
                in_sol   = (x == 0);
                in_sof   = (x == 0) && (y == 0);
                in_eof   = (x == w-1) && (y == h-1);
                in_a     = 8'(img_a[y][x]);
                in_b     = 8'(img_b[y][x]);
                e.chk = (x >= 2) && (y >= 2);
                e.gx  = e.chk ? grad_model(1'b0, x-1, y-1) : 0;
                e.gy  = e.chk ? grad_model(1'b1, x-1, y-1) : 0;
                gq.push_back(e);
                if (!((x == w-1) && (y == h-1))) begin
                    for (int g = 0; g < gap; g++) begin
                        @(negedge clk);
                        in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
                    end
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic finish_frame(input int w, input int h, input string req);
        longint exp[NA];
        @(negedge clk);
        check("R8", longint'(frame_done), 0, "done two cycles after last pixel");
        @(negedge clk);
        check("R8", longint'(frame_done), 1, "done three cycles after last pixel");
        @(negedge clk);
        check("R8", longint'(frame_done), 0, "done pulse width");
        for (int i = 0; i < NA; i++) exp[i] = 0;
        for (int yc = 1; yc <= h-2; yc++)
            for (int xc = 1; xc <= w-2; xc++) begin
                int ix, iy, it;
                if (mask_en && (img_a[yc][xc] == int'(mask_code) || img_b[yc][xc] == int'(mask_code)))
                    continue;
                ix = grad_model(1'b0, xc, yc);
                iy = grad_model(1'b1, xc, yc);
                it = it_sub ? img_a[yc][xc] - img_b[yc][xc] : img_a[yc][xc] + img_b[yc][xc];
                for (int i = 0; i < NA; i++)
                    exp[i] += fac(cf_a[i], ix, iy, it) * fac(cf_b[i], ix, iy, it) * wt(cf_w[i], xc, yc);
            end
        for (int i = 0; i < NA; i++) begin
            rd_sel = 3'(i);
            #1;
            check(req, longint'($signed(rd_data)), exp[i], $sformatf("total %0d", i));
        end
        for (int i = NA; i < 8; i++) begin
            rd_sel = 3'(i);
            #1;
            check("R8", longint'($signed(rd_data)), 0, "unused select");
        end
        rd_sel = '0;
    endtask

    // monitor: pops one expected gradient per result, checks hold while idle
    logic signed [GW-1:0] last_gx = '0, last_gy = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (grad_valid) begin
                if (gq.size() == 0) begin
                    check("R1", 1, 0, "unexpected gradient");
                end else begin
                    gexp_t e;
                    e = gq.pop_front();
                    if (e.chk) begin
                        check("R1", longint'(gx_out), longint'(e.gx), "horizontal gradient");
                        check("R1", longint'(gy_out), longint'(e.gy), "vertical gradient");
                    end
                end
                last_gx <= gx_out;
                last_gy <= gy_out;
            end else begin
                check("R9", longint'(gx_out), longint'(last_gx), "gx hold while idle");
                check("R9", longint'(gy_out), longint'(last_gy), "gy hold while idle");
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R7: reset state
        check("R7", longint'(grad_valid), 0, "grad_valid in reset");
        check("R7", longint'(frame_done), 0, "frame_done in reset");
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #1;
            check("R7", longint'($signed(rd_data)), 0, "total after reset");
        end
        rd_sel = '0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // frame 1: ramps, standard kernels, all six weights of Ix*Ix (R3 R4 R5)
        for (int y = 0; y < 6; y++)
            for (int x = 0; x < 8; x++) begin
                img_a[y][x] = 3*x + 5*y + (x*y) % 7;
                img_b[y][x] = 2*x + y + 1;
            end
        kd = '{-1, 0, 1};
        ks = '{1, 2, 1};
        for (int i = 0; i < NA; i++) begin cf_a[i] = 0; cf_b[i] = 0; cf_w[i] = i; end
        it_sub = 1'b1; mask_en = 1'b0; mask_code = 8'd0;
        apply_cfg();
        drive_frame(8, 6, 0);
        finish_frame(8, 6, "R3 R4 R5");

        // frame 2: random data, sum mode, masking on, mixed terms (R2 R4 R6 R7)
        for (int y = 0; y < 7; y++)
            for (int x = 0; x < 10; x++) begin
                img_a[y][x] = rnd8() | 1;
                img_b[y][x] = rnd8() | 1;
            end
        img_a[3][4] = 0;
        img_b[2][5] = 0;
        cf_a = '{0, 1, 2, 1, 0, 3};
        cf_b = '{1, 2, 0, 1, 2, 0};
        cf_w = '{0, 1, 2, 4, 5, 0};
        it_sub = 1'b0; mask_en = 1'b1; mask_code = 8'd0;
        apply_cfg();
        drive_frame(10, 7, 0);
        finish_frame(10, 7, "R2 R4 R6 R7");

        // frame 3: idle gaps, other kernels, difference mode, mask off (R1 R2 R3 R6 R9)
        for (int y = 0; y < 5; y++)
            for (int x = 0; x < 9; x++) begin
                img_a[y][x] = rnd8();
                img_b[y][x] = rnd8();
            end
        img_a[2][3] = 0;
        kd = '{1, -2, 1};
        ks = '{0, 1, 2};
        cf_a = '{0, 1, 0, 2, 0, 1};
        cf_b = '{0, 1, 1, 2, 2, 2};
        cf_w = '{1, 2, 3, 0, 4, 5};
        it_sub = 1'b1; mask_en = 1'b0; mask_code = 8'd0;
        apply_cfg();
        drive_frame(9, 5, 2);
        finish_frame(9, 5, "R2 R3 R6");

        repeat (3) @(negedge clk);
        check("R1", longint'(gq.size()), 0, "gradients left unmatched");
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule